// File: doc/BRIEF.md
# Reservation Station with Tag Wakeup

This block is a small in-order holding queue in front of one execution unit. Each slot keeps an opcode, the rename tag where the result will go, and two source operand fields. A source field either carries a ready operand value or, while the producer has not yet finished, that producer's rename tag. A per-field valid bit tells which of the two it holds.

New work arrives on the issue port and is appended at the tail. Finished results come back on a broadcast bus as a (tag, value) pair. Every waiting field whose tag equals the broadcast tag captures the value and becomes ready. Only the head slot is ever considered for dispatch. It leaves when both of its operands are ready and the execution unit reports that it can accept work. A flush input empties the queue in a single cycle.

Top module: `rs_wakeup`

## Requirements
- R1: After reset the queue is empty: `issueReady` is 1 and `dispValid` is 0.
- R2: A source field whose valid input is 1 is stored and later dispatched as the operand value. When its valid input is 0, bits [TAG_W-1:0] of the field are the producer's rename tag and the upper bits are ignored.
- R3: `issueReady` is 1 exactly when fewer than DEPTH entries are held. An issue is accepted on a rising edge where `issueValid` and `issueReady` are both 1. An issue presented while the queue is full is dropped and never dispatched.
- R4: `dispValid` is 1 only when the queue is not empty, both sources of the oldest entry are ready, `euFree` is 1 and `flush` is 0. A ready younger entry never leaves ahead of the oldest one. The entry is removed on the edge where `dispValid` is 1.
- R5: On a rising edge with `resValid` at 1, every waiting source field in any held entry whose tag equals `resTag` takes `resData` and becomes ready. This includes both fields of one entry at once.
- R6: Matching uses only the rename tag on `resTag`. A broadcast with a different tag leaves waiting fields untouched.
- R7: If an issued field is waiting on the tag being broadcast in the same cycle, the entry is stored with `resData` and marked ready.
- R8: `flush` at 1 empties the queue at the next edge. It overrides a simultaneous issue, which is dropped, and it holds `dispValid` at 0 during that cycle.
- R9: While `dispValid` is 1, `dispOp`, `dispDstTag`, `dispSrcA` and `dispSrcB` show the oldest entry's opcode, destination tag and two operand values.
- R10: A broadcast in the same cycle as a dispatch wakes the remaining entries, and the dispatched entry leaves with the values it already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every held entry |
| issueValid | input | 1 | New entry offered |
| issueReady | output | 1 | Queue has room |
| issueOp | input | OP_W | Opcode of the new entry |
| issueDstTag | input | TAG_W | Rename tag of the new entry's result |
| issueSrcAValid | input | 1 | Source A field holds a value |
| issueSrcA | input | DATA_W | Source A value, or tag in low bits |
| issueSrcBValid | input | 1 | Source B field holds a value |
| issueSrcB | input | DATA_W | Source B value, or tag in low bits |
| resValid | input | 1 | Result broadcast present |
| resTag | input | TAG_W | Rename tag of the broadcast result |
| resData | input | DATA_W | Broadcast result value |
| euFree | input | 1 | Execution unit can accept an entry |
| dispValid | output | 1 | Oldest entry is leaving this cycle |
| dispOp | output | OP_W | Opcode of dispatched entry |
| dispDstTag | output | TAG_W | Destination tag of dispatched entry |
| dispSrcA | output | DATA_W | Source A operand value |
| dispSrcB | output | DATA_W | Source B operand value |

## Verification
The assertions assume that the issue side honours `issueReady`, so that occupancy never goes above DEPTH. They also assume that `euFree` is the only consumer-side gate, so every cycle with `dispValid` at 1 removes exactly one entry. The stimulus produces broadcasts only for tags drawn from the same small pool used for waiting operands, so waiting entries are eventually woken. The random phase also keeps offering issues while the queue is full, to confirm they are dropped. Flushes arrive at random points, sometimes together with an issue or a broadcast.

// File: rtl/rs_wakeup_pkg.sv
package rs_wakeup_pkg;
  // Strobes from control to datapath, one per cycle.
  typedef struct packed {
    logic push;   // write the issue fields at the tail slot
    logic pop;    // head slot leaves toward the execution unit
    logic clear;  // flush: pointers return to zero
  } rsStrobe_t;
endpackage

// File: rtl/rs_wakeup_fwd.sv
// Forwards a same-cycle broadcast into an operand field that is being issued.
module rs_wakeup_fwd #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              inValid,
  input  logic [DATA_W-1:0] inField,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resData,
  output logic              outValid,
  output logic [DATA_W-1:0] outField
);
  logic hit;
  assign hit      = !inValid && resValid && (inField[TAG_W-1:0] == resTag);
  assign outValid = inValid || hit;
  assign outField = hit ? resData : inField;
endmodule

// File: rtl/rs_wakeup_ctrl.sv
module rs_wakeup_ctrl
  import rs_wakeup_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             issueValid,
  input  logic             euFree,
  input  logic             headReady,
  output logic             issueReady,
  output logic             dispValid,
  output rsStrobe_t        strobe,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [CNT_W-1:0] occupancy
);
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign issueReady   = count < CNT_W'(DEPTH);
  assign dispValid    = (count != '0) && headReady && euFree && !flush;
  assign strobe.push  = issueValid && issueReady && !flush;
  assign strobe.pop   = dispValid;
  assign strobe.clear = flush;
  assign occupancy    = count;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.pop)  headPtr <= stepPtr(headPtr);
      if (strobe.push) tailPtr <= stepPtr(tailPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rs_wakeup_data.sv
module rs_wakeup_data
  import rs_wakeup_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SRCS  = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rsStrobe_t                   strobe,
  input  logic [PTR_W-1:0]            headPtr,
  input  logic [PTR_W-1:0]            tailPtr,
  input  logic [OP_W-1:0]             issueOp,
  input  logic [TAG_W-1:0]            issueDstTag,
  input  logic [SRCS-1:0]             issueSlotValid,
  input  logic [SRCS-1:0][DATA_W-1:0] issueSlot,
  input  logic                        resValid,
  input  logic [TAG_W-1:0]            resTag,
  input  logic [DATA_W-1:0]           resData,
  output logic                        headReady,
  output logic [OP_W-1:0]             dispOp,
  output logic [TAG_W-1:0]            dispDstTag,
  output logic [SRCS-1:0][DATA_W-1:0] dispSlot
);
  logic [OP_W-1:0]             opArr     [DEPTH];
  logic [TAG_W-1:0]            dstArr    [DEPTH];
  logic [SRCS-1:0][DATA_W-1:0] slotVal   [DEPTH];
  logic [SRCS-1:0]             slotValid [DEPTH];
  logic [SRCS-1:0]             wake      [DEPTH];
  logic [SRCS-1:0]             fwdValid;
  logic [SRCS-1:0][DATA_W-1:0] fwdField;

  // Same-cycle broadcast bypass, one per source field of the incoming entry.
  for (genvar s = 0; s < SRCS; s++) begin : g_fwd
    rs_wakeup_fwd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_fwd (
      .inValid (issueSlotValid[s]),
      .inField (issueSlot[s]),
      .resValid(resValid),
      .resTag  (resTag),
      .resData (resData),
      .outValid(fwdValid[s]),
      .outField(fwdField[s])
    );
  end

  // Associative tag compare across every stored source field.
  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    for (genvar s = 0; s < SRCS; s++) begin : g_src
      assign wake[e][s] = resValid && !slotValid[e][s] &&
                          (slotVal[e][s][TAG_W-1:0] == resTag);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rstN) begin
        opArr[e]     <= '0;
        dstArr[e]    <= '0;
        slotVal[e]   <= '0;
        slotValid[e] <= '0;
      end else if (strobe.push && (tailPtr == PTR_W'(e))) begin
        opArr[e]     <= issueOp;
        dstArr[e]    <= issueDstTag;
        slotVal[e]   <= fwdField;
        slotValid[e] <= fwdValid;
      end else begin
        for (int s = 0; s < SRCS; s++) begin
          if (wake[e][s]) begin
            slotVal[e][s]   <= resData;
            slotValid[e][s] <= 1'b1;
          end
        end
      end
    end
  end

  assign headReady  = &slotValid[headPtr];
  assign dispOp     = opArr[headPtr];
  assign dispDstTag = dstArr[headPtr];
  assign dispSlot   = slotVal[headPtr];
endmodule

// File: rtl/rs_wakeup.sv
module rs_wakeup
  import rs_wakeup_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [TAG_W-1:0]  issueDstTag,
  input  logic              issueSrcAValid,
  input  logic [DATA_W-1:0] issueSrcA,
  input  logic              issueSrcBValid,
  input  logic [DATA_W-1:0] issueSrcB,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resData,
  input  logic              euFree,
  output logic              dispValid,
  output logic [OP_W-1:0]   dispOp,
  output logic [TAG_W-1:0]  dispDstTag,
  output logic [DATA_W-1:0] dispSrcA,
  output logic [DATA_W-1:0] dispSrcB
);
  rsStrobe_t              strobe;
  logic [PTR_W-1:0]       headPtr;
  logic [PTR_W-1:0]       tailPtr;
  logic [CNT_W-1:0]       occupancy;
  logic                   headReady;
  logic [1:0][DATA_W-1:0] dispSlot;

  rs_wakeup_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .issueValid(issueValid),
    .euFree    (euFree),
    .headReady (headReady),
    .issueReady(issueReady),
    .dispValid (dispValid),
    .strobe    (strobe),
    .headPtr   (headPtr),
    .tailPtr   (tailPtr),
    .occupancy (occupancy)
  );

  rs_wakeup_data #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .headPtr       (headPtr),
    .tailPtr       (tailPtr),
    .issueOp       (issueOp),
    .issueDstTag   (issueDstTag),
    .issueSlotValid({issueSrcBValid, issueSrcAValid}),
    .issueSlot     ({issueSrcB, issueSrcA}),
    .resValid      (resValid),
    .resTag        (resTag),
    .resData       (resData),
    .headReady     (headReady),
    .dispOp        (dispOp),
    .dispDstTag    (dispDstTag),
    .dispSlot      (dispSlot)
  );

  assign dispSrcA = dispSlot[0];
  assign dispSrcB = dispSlot[1];
endmodule

// File: rtl/rs_wakeup_checker.sv
module rs_wakeup_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             issueValid,
  input logic             issueReady,
  input logic             euFree,
  input logic             dispValid,
  input logic [CNT_W-1:0] occupancy
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(occupancy) <= DEPTH);

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(occupancy) == DEPTH) |-> !issueReady);

  p_count_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> int'(occupancy) == int'($past(occupancy))
                + ($past(issueValid && issueReady) ? 1 : 0)
                - ($past(dispValid) ? 1 : 0));

  p_eu_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (euFree && occupancy != '0));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !dispValid ##1 (occupancy == '0 && issueReady));
endmodule

bind rs_wakeup rs_wakeup_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .flush     (flush),
  .issueValid(issueValid),
  .issueReady(issueReady),
  .euFree    (euFree),
  .dispValid (dispValid),
  .occupancy (occupancy)
);

// File: tb/rs_wakeup_bench.sv
module rs_wakeup_bench;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 4;

  typedef struct {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  dst;
    logic              aV;
    logic [DATA_W-1:0] a;
    logic              bV;
    logic [DATA_W-1:0] b;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, issueValid = 1'b0, issueReady;
  logic [OP_W-1:0] issueOp = '0;
  logic [TAG_W-1:0] issueDstTag = '0;
  logic issueSrcAValid = 1'b0, issueSrcBValid = 1'b0;
  logic [DATA_W-1:0] issueSrcA = '0, issueSrcB = '0;
  logic resValid = 1'b0;
  logic [TAG_W-1:0] resTag = '0;
  logic [DATA_W-1:0] resData = '0;
  logic euFree = 1'b0, dispValid;
  logic [OP_W-1:0] dispOp;
  logic [TAG_W-1:0] dispDstTag;
  logic [DATA_W-1:0] dispSrcA, dispSrcB;

  int checks = 0, failures = 0, dispatched = 0;
  bit done = 0;
  string scen = "";
  item_t sb[$];

  always #5 clk = ~clk;

  rs_wakeup u_rs_wakeup (.*);

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, scen, act, exp);
    end
  endtask

  // Driver: offer one entry this cycle.
  task automatic drive(logic [OP_W-1:0] op, logic [TAG_W-1:0] dst,
                       logic aV, logic [DATA_W-1:0] a, logic bV, logic [DATA_W-1:0] b);
    issueValid = 1; issueOp = op; issueDstTag = dst;
    issueSrcAValid = aV; issueSrcA = a; issueSrcBValid = bV; issueSrcB = b;
  endtask

  task automatic bcast(logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    resValid = 1; resTag = t; resData = d;
  endtask

  // One cycle: monitor compares outputs with the scoreboard, then the model
  // absorbs this cycle's inputs. Called just after a falling edge.
  task automatic step();
    bit expDisp, canIssue;
    item_t n;
    #1;
    canIssue = sb.size() < DEPTH;
    check("R3 issueReady", DATA_W'(issueReady), DATA_W'(canIssue));
    expDisp = sb.size() > 0 && sb[0].aV && sb[0].bV && euFree && !flush;
    check("R4 dispValid", DATA_W'(dispValid), DATA_W'(expDisp));
    if (expDisp) begin
      check("R9 dispOp", DATA_W'(dispOp), DATA_W'(sb[0].op));
      check("R9 dispDstTag", DATA_W'(dispDstTag), DATA_W'(sb[0].dst));
      check("R2 dispSrcA", dispSrcA, sb[0].a);
      check("R2 dispSrcB", dispSrcB, sb[0].b);
      void'(sb.pop_front());
      dispatched++;
    end
    if (flush) sb.delete();
    else begin
      if (resValid)
        foreach (sb[i]) begin
          if (!sb[i].aV && sb[i].a[TAG_W-1:0] == resTag) begin sb[i].aV = 1; sb[i].a = resData; end
          if (!sb[i].bV && sb[i].b[TAG_W-1:0] == resTag) begin sb[i].bV = 1; sb[i].b = resData; end
        end
      if (issueValid && canIssue) begin
        n.op = issueOp; n.dst = issueDstTag;
        n.aV = issueSrcAValid; n.a = issueSrcA; n.bV = issueSrcBValid; n.b = issueSrcB;
        if (!n.aV && resValid && n.a[TAG_W-1:0] == resTag) begin n.aV = 1; n.a = resData; end
        if (!n.bV && resValid && n.b[TAG_W-1:0] == resTag) begin n.bV = 1; n.b = resData; end
        sb.push_back(n);
      end
    end
    @(negedge clk);
    issueValid = 0; resValid = 0; flush = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    scen = "R1 reset";
    #1;
    check("R1 issueReady", DATA_W'(issueReady), 16'd1);
    check("R1 dispValid", DATA_W'(dispValid), 16'd0);
    @(negedge clk);

    scen = "R2 ready operands";
    euFree = 1;
    drive(4'h1, 4'h2, 1, 16'h1111, 1, 16'h2222); step(); idle(2);

    scen = "R4 oldest only";
    euFree = 1;
    drive(4'h2, 4'h4, 0, 16'hAB03, 1, 16'h0005); step();
    drive(4'h3, 4'h5, 1, 16'h0007, 1, 16'h0008); step(); idle(2);
    bcast(4'h3, 16'hBEEF); step(); idle(3);

    scen = "R4 euFree low holds";
    euFree = 0;
    drive(4'h4, 4'h6, 1, 16'h0101, 1, 16'h0202); step(); idle(2);
    euFree = 1; idle(2);

    scen = "R5 both slots one broadcast";
    drive(4'h5, 4'h7, 0, 16'h0005, 0, 16'hFF05); step();
    scen = "R6 other tag ignored";
    bcast(4'h6, 16'h6666); step(); idle(2);
    scen = "R5 both slots one broadcast";
    bcast(4'h5, 16'h5A5A); step(); idle(2);

    scen = "R7 issue-cycle bypass";
    drive(4'h6, 4'h8, 0, 16'h0007, 1, 16'h0003);
    bcast(4'h7, 16'h7777); step(); idle(3);

    scen = "R3 full drops issue";
    euFree = 0;
    for (int i = 0; i < DEPTH; i++) begin
      drive(OP_W'(i), TAG_W'(i), 0, 16'h0009, 1, DATA_W'(i)); step();
    end
    drive(4'hF, 4'hF, 1, 16'hDEAD, 1, 16'hDEAD); step();
    bcast(4'h9, 16'h9999); step();
    euFree = 1; idle(DEPTH + 2);

    scen = "R8 flush with issue";
    euFree = 0;
    drive(4'h1, 4'h1, 1, 16'h1, 1, 16'h1); step();
    drive(4'h2, 4'h2, 1, 16'h2, 1, 16'h2); step();
    euFree = 1; flush = 1;
    drive(4'h3, 4'h3, 1, 16'h3, 1, 16'h3); step(); idle(2);

    scen = "R10 wake during dispatch";
    euFree = 0;
    drive(4'h7, 4'hA, 1, 16'h00A1, 1, 16'h00A2); step();
    drive(4'h8, 4'hB, 0, 16'h000C, 1, 16'h00B2); step();
    euFree = 1;
    bcast(4'hC, 16'hC0C0); step(); idle(3);

    scen = "random mix R5 R6 R7 R8";
    for (int i = 0; i < 600; i++) begin
      euFree = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 1) == 1)
        drive(OP_W'($urandom()), TAG_W'($urandom()),
              $urandom_range(0, 1) == 1, DATA_W'($urandom_range(0, 7) | ($urandom() << 4)),
              $urandom_range(0, 1) == 1, DATA_W'($urandom_range(0, 7) | ($urandom() << 4)));
      if ($urandom_range(0, 2) != 0) bcast(TAG_W'($urandom_range(0, 7)), DATA_W'($urandom()));
      if ($urandom_range(0, 59) == 0) flush = 1;
      step();
    end
    scen = "drain";
    euFree = 1;
    for (int t = 0; t < 8; t++) begin bcast(TAG_W'(t), DATA_W'(16'h100 + t)); step(); end
    idle(DEPTH + 2);
    check("R4 drained", DATA_W'(dispValid), 16'd0);
    checks++;
    if (dispatched < 20) begin
      failures++;
      $display("FAIL R4 too few dispatches actual=%0d expected>=20", dispatched);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule